// File: doc/BRIEF.md
# Sv39 Access Permission and Fault Checker

This block is a purely combinational stage that follows a translation lookup. It is given the kind of access, the hart's privilege state, the translation mode and the flags of the leaf page-table entry. From these it works out the privilege the access runs at and decides whether translation applies at all. It then produces the physical address, reports at most one fault with its cause code, and says whether a store should trigger a fresh page-table walk.

Access kind encoding: 2'b00 load, 2'b01 store, 2'b10 or 2'b11 instruction fetch. Privilege encoding: 0 user, 1 supervisor, 3 machine; the value 2 gets no user-page checks. A translation mode of 0 means bare, and any non-zero value means translated (8 is the usual Sv39 value).

Top module: `sv39_perm_check`

## Requirements
- R1: The effective privilege is `mpp` when `mprv` is 1 and the access is a load or store. Otherwise it is `cur_priv`; in particular, a fetch always uses `cur_priv`.
- R2: `bypass` is 1 exactly when the effective privilege is 3 or `xlat_mode` is 0. While bypassed, `paddr` equals `vaddr` and no page fault is raised.
- R3: When not bypassed, `paddr` equals `xlat_paddr`.
- R4: When not bypassed, a page fault is raised in three cases: a load with `pte_r` 0, a store with `pte_w` 0, or a fetch with `pte_x` 0.
- R5: When the R4 check passes, a user-level access to a page with `pte_u` 0 raises a page fault.
- R6: When the R4 check passes, a supervisor-level access to a page with `pte_u` 1 raises a page fault if `sum` is 0. It raises none if `sum` is 1.
- R7: Page-fault causes are 13 for a load, 15 for a store and 12 for a fetch.
- R8: With no page fault and bit PA_W-1 of `paddr` set, an access fault is raised. Its cause is 5 for a load, 7 for a store and 1 for a fetch. A page fault takes precedence over it.
- R9: With no fault, `fault` is 0 and `cause` is 0. When `fault` is 1, `cause` is non-zero.
- R10: `rewalk` is 1 exactly when the access is a store, it is not bypassed and `pte_w` is 0. Such a store also reports page fault 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_kind | input | 2 | Access kind (00 load, 01 store, 1x fetch) |
| cur_priv | input | 2 | Current privilege level |
| mprv | input | 1 | Modify-privilege status bit |
| mpp | input | 2 | Previous machine privilege field |
| sum | input | 1 | Supervisor may access user pages |
| xlat_mode | input | MODE_W | Translation mode, 0 is bare |
| pte_r | input | 1 | Leaf entry readable |
| pte_w | input | 1 | Leaf entry writable |
| pte_x | input | 1 | Leaf entry executable |
| pte_u | input | 1 | Leaf entry user page |
| vaddr | input | PA_W | Virtual address |
| xlat_paddr | input | PA_W | Physical address from the lookup |
| bypass | output | 1 | Translation skipped |
| paddr | output | PA_W | Resulting physical address |
| fault | output | 1 | A fault is reported |
| cause | output | CAUSE_W | Fault cause code, 0 if none |
| rewalk | output | 1 | Store needs a new table walk |

## Verification
The bench builds the block with its defaults: a 64-bit address, a 4-bit mode field and a 5-bit cause. With a full 64-bit address, random values set the top address bit about half the time. That means the access-fault path and its precedence under page faults are both hit often. Random stimulus covers all four privilege encodings, every combination of `mprv` and `mpp`, and both bare and non-bare modes. On top of that, directed cases target the corners: a fetch ignoring `mprv`, and a store with W clear that must request a new walk.

// File: rtl/sv39_perm_check.sv
module sv39_perm_check #(
  parameter int PA_W    = 64,
  parameter int MODE_W  = 4,
  parameter int CAUSE_W = 5
) (
  input  logic [1:0]         acc_kind,
  input  logic [1:0]         cur_priv,
  input  logic               mprv,
  input  logic [1:0]         mpp,
  input  logic               sum,
  input  logic [MODE_W-1:0]  xlat_mode,
  input  logic               pte_r,
  input  logic               pte_w,
  input  logic               pte_x,
  input  logic               pte_u,
  input  logic [PA_W-1:0]    vaddr,
  input  logic [PA_W-1:0]    xlat_paddr,
  output logic               bypass,
  output logic [PA_W-1:0]    paddr,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause,
  output logic               rewalk
);

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [CAUSE_W-1:0] C_NONE   = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] C_LD_PG  = CAUSE_W'(13);
  localparam logic [CAUSE_W-1:0] C_ST_PG  = CAUSE_W'(15);
  localparam logic [CAUSE_W-1:0] C_IF_PG  = CAUSE_W'(12);
  localparam logic [CAUSE_W-1:0] C_LD_ACC = CAUSE_W'(5);
  localparam logic [CAUSE_W-1:0] C_ST_ACC = CAUSE_W'(7);
  localparam logic [CAUSE_W-1:0] C_IF_ACC = CAUSE_W'(1);

  logic       is_load, is_store, is_fetch;
  logic [1:0] eff_priv;
  logic       perm_miss, priv_miss, pg_fault, acc_fault;

  assign is_load  = (acc_kind == 2'b00);
  assign is_store = (acc_kind == 2'b01);
  assign is_fetch = acc_kind[1];

  assign eff_priv = (mprv && !is_fetch) ? mpp : cur_priv;

  assign bypass = (eff_priv == PRIV_M) || (xlat_mode == '0);
  assign paddr  = bypass ? vaddr : xlat_paddr;

  assign perm_miss = (is_load && !pte_r) || (is_store && !pte_w) || (is_fetch && !pte_x);
  assign priv_miss = !perm_miss &&
                     (((eff_priv == PRIV_U) && !pte_u) ||
                      ((eff_priv == PRIV_S) && pte_u && !sum));

  assign pg_fault  = !bypass && (perm_miss || priv_miss);
  assign acc_fault = !pg_fault && paddr[PA_W-1];
  assign fault     = pg_fault || acc_fault;
  assign rewalk    = !bypass && is_store && !pte_w;

  always_comb begin
    cause = C_NONE;
    if (pg_fault) begin
      if (is_load)       cause = C_LD_PG;
      else if (is_store) cause = C_ST_PG;
      else               cause = C_IF_PG;
    end else if (acc_fault) begin
      if (is_load)       cause = C_LD_ACC;
      else if (is_store) cause = C_ST_ACC;
      else               cause = C_IF_ACC;
    end
  end

  always_comb begin
    if (fault) AST_CAUSE_SET: assert (cause != C_NONE); // R9
    if (!fault) AST_CAUSE_CLEAR: assert (cause == C_NONE); // R9
    if (bypass) AST_BYPASS_PA: assert (paddr == vaddr); // R2
    if (cur_priv == PRIV_M && is_fetch) AST_FETCH_M_BYPASS: assert (bypass); // R1
    if (rewalk) AST_REWALK_FAULT: assert (fault && cause == C_ST_PG); // R10
    if (!fault) AST_PA_TOP_CLEAR: assert (!paddr[PA_W-1]); // R8
  end

endmodule

// File: tb/sv39_perm_check_tb.sv
module sv39_perm_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 64;
  localparam int MODE_W = 4;
  localparam int CAUSE_W = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] acc_kind, cur_priv, mpp;
  logic mprv, sum, pte_r, pte_w, pte_x, pte_u;
  logic [MODE_W-1:0] xlat_mode;
  logic [PA_W-1:0] vaddr, xlat_paddr, paddr;
  logic bypass, fault, rewalk;
  logic [CAUSE_W-1:0] cause;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  sv39_perm_check #(.PA_W(PA_W), .MODE_W(MODE_W), .CAUSE_W(CAUSE_W)) dut_i (
    .acc_kind(acc_kind), .cur_priv(cur_priv), .mprv(mprv), .mpp(mpp), .sum(sum),
    .xlat_mode(xlat_mode), .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .pte_u(pte_u),
    .vaddr(vaddr), .xlat_paddr(xlat_paddr), .bypass(bypass), .paddr(paddr),
    .fault(fault), .cause(cause), .rewalk(rewalk));

  // expected: {bypass, fault, cause[4:0], rewalk}
  function automatic logic [7:0] model();
    logic [1:0] ep;
    logic ld, st, fe, byp, pm, pf, af, rw;
    logic [PA_W-1:0] pa;
    logic [4:0] c;
    ld = (acc_kind == 2'b00); st = (acc_kind == 2'b01); fe = acc_kind[1];
    ep = (mprv && !fe) ? mpp : cur_priv;
    byp = (ep == 2'd3) || (xlat_mode == 0);
    pa = byp ? vaddr : xlat_paddr;
    pm = (ld && !pte_r) || (st && !pte_w) || (fe && !pte_x);
    pf = !byp && (pm || (ep == 2'd0 && !pte_u) || (ep == 2'd1 && pte_u && !sum));
    af = !pf && pa[PA_W-1];
    c = 5'd0;
    if (pf) c = ld ? 5'd13 : st ? 5'd15 : 5'd12;
    else if (af) c = ld ? 5'd5 : st ? 5'd7 : 5'd1;
    rw = !byp && st && !pte_w;
    return {byp, pf || af, c, rw};
  endfunction

  function automatic logic [PA_W-1:0] model_pa();
    logic ep3;
    ep3 = ((mprv && !acc_kind[1]) ? mpp : cur_priv) == 2'd3;
    return (ep3 || xlat_mode == 0) ? vaddr : xlat_paddr;
  endfunction

  task automatic check(input string req);
    logic [7:0] exp;
    logic [PA_W-1:0] epa;
    #1;
    exp = model();
    epa = model_pa();
    n_chk++;
    if ({bypass, fault, cause, rewalk} !== exp || paddr !== epa) begin
      n_fail++;
      $display("FAIL %s: got byp=%0b flt=%0b cause=%0d rw=%0b pa=%h, exp byp=%0b flt=%0b cause=%0d rw=%0b pa=%h",
               req, bypass, fault, cause, rewalk, paddr, exp[7], exp[6], exp[5:1], exp[0], epa);
    end
  endtask

  task automatic expect_cause(input string req, input logic f, input logic [4:0] c);
    n_chk++;
    if (fault !== f || cause !== c) begin
      n_fail++;
      $display("FAIL %s: got fault=%0b cause=%0d, exp fault=%0b cause=%0d", req, fault, cause, f, c);
    end
  endtask

  task automatic set(input logic [1:0] k, input logic [1:0] cp, input logic mp, input logic [1:0] pp,
                     input logic s, input logic [3:0] md, input logic [3:0] rwxu,
                     input logic [PA_W-1:0] va, input logic [PA_W-1:0] pa);
    acc_kind = k; cur_priv = cp; mprv = mp; mpp = pp; sum = s; xlat_mode = md;
    {pte_r, pte_w, pte_x, pte_u} = rwxu; vaddr = va; xlat_paddr = pa;
  endtask

  localparam logic [PA_W-1:0] LO = 64'h0000_0000_8000_1000;
  localparam logic [PA_W-1:0] HI = 64'h8000_0000_0000_2000;

  initial begin
    void'($urandom(32'd1234));
    // R9 idle: S load on readable supervisor page
    set(2'b00, 2'd1, 0, 2'd0, 0, 4'd8, 4'b1000, LO, LO); check("R9"); expect_cause("R9", 0, 0);
    // R1 mprv with mpp=U makes M-mode load translated and subject to U check
    set(2'b00, 2'd3, 1, 2'd0, 0, 4'd8, 4'b1000, LO, LO); check("R1"); expect_cause("R1", 1, 13);
    // R1 fetch ignores mprv: stays M, bypassed
    set(2'b10, 2'd3, 1, 2'd0, 0, 4'd8, 4'b0000, LO, HI); check("R1"); expect_cause("R1", 0, 0);
    // R2 bare mode bypasses, paddr=vaddr
    set(2'b01, 2'd0, 0, 2'd0, 0, 4'd0, 4'b0000, LO, HI); check("R2"); expect_cause("R2", 0, 0);
    // R3 translated address used
    set(2'b00, 2'd0, 0, 2'd0, 0, 4'd8, 4'b1001, HI, LO); check("R3"); expect_cause("R3", 0, 0);
    // R4/R7 each missing permission
    set(2'b00, 2'd1, 0, 2'd0, 0, 4'd8, 4'b0110, LO, LO); check("R4"); expect_cause("R7", 1, 13);
    set(2'b01, 2'd1, 0, 2'd0, 0, 4'd8, 4'b1010, LO, LO); check("R4"); expect_cause("R7", 1, 15);
    set(2'b10, 2'd1, 0, 2'd0, 0, 4'd8, 4'b1100, LO, LO); check("R4"); expect_cause("R7", 1, 12);
    // R10 store, W clear -> rewalk
    n_chk++; if (0) ;
    set(2'b01, 2'd0, 0, 2'd0, 0, 4'd8, 4'b1011, LO, LO); check("R10");
    if (rewalk !== 1'b1) begin n_fail++; $display("FAIL R10: rewalk=%0b exp 1", rewalk); end
    // R5 user access to supervisor page
    set(2'b11, 2'd0, 0, 2'd0, 1, 4'd8, 4'b0010, LO, LO); check("R5"); expect_cause("R5", 1, 12);
    // R6 supervisor on user page, sum=0 then sum=1
    set(2'b01, 2'd1, 0, 2'd0, 0, 4'd8, 4'b0101, LO, LO); check("R6"); expect_cause("R6", 1, 15);
    set(2'b01, 2'd1, 0, 2'd0, 1, 4'd8, 4'b0101, LO, LO); check("R6"); expect_cause("R6", 0, 0);
    // R8 access faults, and page fault precedence
    set(2'b00, 2'd1, 0, 2'd0, 0, 4'd8, 4'b1000, LO, HI); check("R8"); expect_cause("R8", 1, 5);
    set(2'b01, 2'd3, 0, 2'd0, 0, 4'd8, 4'b0000, HI, LO); check("R8"); expect_cause("R8", 1, 7);
    set(2'b10, 2'd0, 0, 2'd0, 0, 4'd0, 4'b0000, HI, LO); check("R8"); expect_cause("R8", 1, 1);
    set(2'b00, 2'd1, 0, 2'd0, 0, 4'd8, 4'b0000, LO, HI); check("R8"); expect_cause("R8", 1, 13);
    for (int i = 0; i < 3000; i++) begin
      set(2'($urandom), 2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
          ($urandom % 3 == 0) ? 4'd0 : 4'd8, 4'($urandom),
          {$urandom, $urandom}, {$urandom, $urandom});
      check("R1..R10 random");
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule